// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block decides when the chip's internal reset may be lifted. It watches two supply-level flags that form a hysteresis pair: one says the supply has risen high enough, the other says it has fallen too low. It also watches an active-low external reset pin and a strap that says whether low-voltage detection is enabled. All inputs are already synchronous to the free-running on-chip oscillator clock, and every wait is a parameter counted in cycles of that clock.

A fall flag forces the power-on state at once. After a rise flag the block waits out a supply stabilization interval. It then holds reset for as long as the external pin is low. When the pin goes high, it runs a reset processing interval and then releases. The processing interval is longer for the first release after power-on than for later ones, and longer with the detector enabled than without. One down-counter times all intervals, loaded from a four-way choice. The pin passes through a qualifier, so a low pulse shorter than a set number of cycles does nothing. A qualified low pulse, or a fall flag, aborts any processing in progress. After release the CPU runs from the on-chip oscillator. A status flag marks a sequence that is the first one after power-on.

Top module: `rst_release_seq`

## Requirements
- R1: While `supply_down` is sampled high, the next cycle shows `sys_rst`=1, `cpu_run`=0 and `first_rel`=1. This applies in every state.
- R2: With the pin high and `supply_down` low, `sys_rst` falls exactly STAB_CYC+1+T cycles after the clock edge that first samples `supply_up` high in the power-on state. T is the processing time chosen by R4.
- R3: Once the stabilization wait has ended, `sys_rst` stays 1 for as long as `ext_rst_n` is sampled low. Processing begins at the first edge that samples the pin high, and `sys_rst` falls T cycles later.
- R4: For the first release after power-on, T is FIRST_LVD_CYC when `lvd_en`=1 and FIRST_NOLVD_CYC when `lvd_en`=0.
- R5: For every later release, T is SUB_LVD_CYC when `lvd_en`=1 and SUB_NOLVD_CYC when `lvd_en`=0.
- R6: `lvd_en` is sampled only at the edge where processing begins. The interval length is fixed from that edge on.
- R7: While running, a low run on `ext_rst_n` of fewer than FILT_CYC consecutive samples has no effect. `cpu_run` stays 1 throughout.
- R8: A low run of FILT_CYC consecutive samples is a valid external reset. `sys_rst` goes to 1 after the edge of the FILT_CYC-th low sample and stays 1 while the pin is low.
- R9: A valid external reset during processing aborts the count. The full interval restarts when the pin next goes high. A `supply_down` during processing returns the block to the power-on state.
- R10: `first_rel` is set in the power-on state and cleared at the edge where the first release completes. It stays 0 through later external resets.
- R11: `cpu_run` is always the complement of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip oscillator clock |
| supply_up | input | 1 | Supply rise-detected flag |
| supply_down | input | 1 | Supply fall-detected flag; forces the power-on state |
| ext_rst_n | input | 1 | External reset pin, active low |
| lvd_en | input | 1 | Low-voltage detection enabled strap |
| sys_rst | output | 1 | Internal reset, active high |
| cpu_run | output | 1 | CPU run enable from the on-chip oscillator |
| first_rel | output | 1 | The sequence in progress is the first since power-on |

## Verification
The bound checker tests, on every cycle, the properties that depend only on the ports. A fall flag must produce the power-on outputs, and a run with the pin high must continue. A low run of FILT_CYC samples must leave reset asserted. No release may come sooner than the shortest processing time. `first_rel` may only rise after a fall flag, may only clear together with the release, and may never be 1 while running. The exact interval lengths cannot be seen at a single cycle. These are the stabilization plus processing count, the four-way choice of processing time, the restart after an abort, and the point where `lvd_en` is sampled. Only the bench scenarios show them, by measuring release times and comparing every cycle against a reference model.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   typedef enum logic [2:0] {
      ST_POR  = 3'd0,
      ST_STAB = 3'd1,
      ST_WAIT = 3'd2,
      ST_PROC = 3'd3,
      ST_RUN  = 3'd4
   } rrs_state_e;

   function automatic int unsigned rrs_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned rrs_min(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/rrs_pin_qual.sv
module rrs_pin_qual #(
   parameter int unsigned FILT_CYC = 5
) (
   input  logic clk,
   input  logic clr,
   input  logic pin_n,
   output logic valid_o
);
   generate
      if (FILT_CYC <= 1) begin : g_direct
         assign valid_o = ~pin_n;
      end else begin : g_count
         localparam int unsigned QW = $clog2(FILT_CYC + 1);
         localparam logic [QW-1:0] SAT  = QW'(FILT_CYC);
         localparam logic [QW-1:0] LAST = QW'(FILT_CYC - 1);
         logic [QW-1:0] low_q;

         always_ff @(posedge clk) begin
            if (clr || pin_n)     low_q <= '0;
            else if (low_q != SAT) low_q <= low_q + 1'b1;
         end

         assign valid_o = ~pin_n && (low_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/rrs_load_sel.sv
module rrs_load_sel #(
   parameter int unsigned CNT_W           = 6,
   parameter int unsigned STAB_CYC        = 40,
   parameter int unsigned FIRST_LVD_CYC   = 30,
   parameter int unsigned FIRST_NOLVD_CYC = 18,
   parameter int unsigned SUB_LVD_CYC     = 24,
   parameter int unsigned SUB_NOLVD_CYC   = 12
) (
   input  logic             pick_stab,
   input  logic             first,
   input  logic             lvd,
   output logic [CNT_W-1:0] val_o
);
   localparam logic [CNT_W-1:0] V_STAB = CNT_W'(STAB_CYC - 1);
   localparam logic [CNT_W-1:0] V_F1   = CNT_W'(FIRST_LVD_CYC - 1);
   localparam logic [CNT_W-1:0] V_F0   = CNT_W'(FIRST_NOLVD_CYC - 1);
   localparam logic [CNT_W-1:0] V_S1   = CNT_W'(SUB_LVD_CYC - 1);
   localparam logic [CNT_W-1:0] V_S0   = CNT_W'(SUB_NOLVD_CYC - 1);

   always_comb begin
      if (pick_stab)  val_o = V_STAB;
      else if (first) val_o = lvd ? V_F1 : V_F0;
      else            val_o = lvd ? V_S1 : V_S0;
   end
endmodule

// File: rtl/rrs_timer.sv
module rrs_timer #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (clr)               cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq #(
   parameter int unsigned STAB_CYC        = 40,
   parameter int unsigned FILT_CYC        = 5,
   parameter int unsigned FIRST_LVD_CYC   = 30,
   parameter int unsigned FIRST_NOLVD_CYC = 18,
   parameter int unsigned SUB_LVD_CYC     = 24,
   parameter int unsigned SUB_NOLVD_CYC   = 12
) (
   input  logic clk,
   input  logic supply_up,
   input  logic supply_down,
   input  logic ext_rst_n,
   input  logic lvd_en,
   output logic sys_rst,
   output logic cpu_run,
   output logic first_rel
);
   import rrs_pkg::*;

   localparam int unsigned MAX_FIRST = rrs_max(FIRST_LVD_CYC, FIRST_NOLVD_CYC);
   localparam int unsigned MAX_SUB   = rrs_max(SUB_LVD_CYC, SUB_NOLVD_CYC);
   localparam int unsigned MAX_CYC   = rrs_max(rrs_max(STAB_CYC, MAX_FIRST), rrs_max(MAX_SUB, 2));
   localparam int unsigned CNT_W     = $clog2(MAX_CYC);

   generate
      if (STAB_CYC < 1 || FILT_CYC < 1) begin : g_bad_wait
         $error("rst_release_seq: STAB_CYC and FILT_CYC must be at least 1");
      end
      if (SUB_LVD_CYC < 1 || SUB_NOLVD_CYC < 1) begin : g_bad_sub
         $error("rst_release_seq: processing times must be at least 1");
      end
      if (FIRST_LVD_CYC < SUB_LVD_CYC || FIRST_NOLVD_CYC < SUB_NOLVD_CYC) begin : g_bad_order
         $error("rst_release_seq: first release must not be shorter than later ones");
      end
   endgenerate

   rrs_state_e       state_q, state_d;
   logic             first_q, first_d;
   logic             ext_valid, tmr_zero, tmr_load, pick_stab;
   logic [CNT_W-1:0] load_val;

   rrs_pin_qual #(.FILT_CYC(FILT_CYC)) u_qual (
      .clk     (clk),
      .clr     (supply_down),
      .pin_n   (ext_rst_n),
      .valid_o (ext_valid)
   );

   rrs_load_sel #(
      .CNT_W           (CNT_W),
      .STAB_CYC        (STAB_CYC),
      .FIRST_LVD_CYC   (FIRST_LVD_CYC),
      .FIRST_NOLVD_CYC (FIRST_NOLVD_CYC),
      .SUB_LVD_CYC     (SUB_LVD_CYC),
      .SUB_NOLVD_CYC   (SUB_NOLVD_CYC)
   ) u_sel (
      .pick_stab (pick_stab),
      .first     (first_q),
      .lvd       (lvd_en),
      .val_o     (load_val)
   );

   rrs_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .clr      (supply_down),
      .load     (tmr_load),
      .load_val (load_val),
      .zero_o   (tmr_zero)
   );

   always_comb begin
      state_d   = state_q;
      first_d   = first_q;
      tmr_load  = 1'b0;
      pick_stab = 1'b0;
      unique case (state_q)
         ST_POR: begin
            first_d   = 1'b1;
            pick_stab = 1'b1;
            if (supply_up) begin
               state_d  = ST_STAB;
               tmr_load = 1'b1;
            end
         end
         ST_STAB: if (tmr_zero) state_d = ST_WAIT;
         ST_WAIT: begin
            if (ext_rst_n) begin
               state_d  = ST_PROC;
               tmr_load = 1'b1;
            end
         end
         ST_PROC: begin
            if (ext_valid) begin
               state_d = ST_WAIT;
            end else if (tmr_zero) begin
               state_d = ST_RUN;
               first_d = 1'b0;
            end
         end
         ST_RUN: if (ext_valid) state_d = ST_WAIT;
         default: state_d = ST_POR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (supply_down) begin
         state_q <= ST_POR;
         first_q <= 1'b1;
      end else begin
         state_q <= state_d;
         first_q <= first_d;
      end
   end

   assign sys_rst   = (state_q != ST_RUN);
   assign cpu_run   = (state_q == ST_RUN);
   assign first_rel = first_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
   parameter int unsigned FILT_CYC        = 5,
   parameter int unsigned FIRST_LVD_CYC   = 30,
   parameter int unsigned FIRST_NOLVD_CYC = 18,
   parameter int unsigned SUB_LVD_CYC     = 24,
   parameter int unsigned SUB_NOLVD_CYC   = 12
) (
   input logic clk,
   input logic supply_up,
   input logic supply_down,
   input logic ext_rst_n,
   input logic lvd_en,
   input logic sys_rst,
   input logic cpu_run,
   input logic first_rel
);
   import rrs_pkg::*;

   localparam int unsigned MIN_HOLD = rrs_min(rrs_min(FIRST_LVD_CYC, FIRST_NOLVD_CYC),
                                              rrs_min(SUB_LVD_CYC, SUB_NOLVD_CYC));

   int unsigned low_run;
   int unsigned hi_len;

   always_ff @(posedge clk) begin
      if (supply_down)              low_run <= 0;
      else if (ext_rst_n)           low_run <= 0;
      else if (low_run < FILT_CYC)  low_run <= low_run + 1;

      if (supply_down)              hi_len <= 1;
      else if (!sys_rst)            hi_len <= 0;
      else if (hi_len < 32'hFFFF)   hi_len <= hi_len + 1;
   end

   AST_DOWN_FORCES_POR: assert property (@(posedge clk) disable iff (supply_down)
      $past(supply_down) |-> (sys_rst && !cpu_run && first_rel));   // R1
   AST_SHORT_LOW_IGNORED: assert property (@(posedge clk) disable iff (supply_down)
      (cpu_run && ext_rst_n) |=> cpu_run);                           // R7
   AST_LONG_LOW_RESETS: assert property (@(posedge clk) disable iff (supply_down)
      (low_run >= FILT_CYC) |-> sys_rst);                            // R8
   AST_MIN_PROC_HOLD: assert property (@(posedge clk) disable iff (supply_down)
      $fell(sys_rst) |-> (hi_len > MIN_HOLD));                        // R3
   AST_FIRST_SET_BY_POR: assert property (@(posedge clk) disable iff (supply_down)
      $rose(first_rel) |-> $past(supply_down));                      // R10
   AST_FIRST_CLR_AT_REL: assert property (@(posedge clk) disable iff (supply_down)
      $fell(first_rel) |-> $fell(sys_rst));                          // R10
   AST_RUN_NOT_FIRST: assert property (@(posedge clk) disable iff (supply_down)
      cpu_run |-> !first_rel);                                       // R10
   AST_RUN_IS_NOT_RST: assert property (@(posedge clk) disable iff (supply_down)
      $countones({sys_rst, cpu_run}) == 1);                          // R11
endmodule

bind rst_release_seq rrs_checker #(
   .FILT_CYC        (FILT_CYC),
   .FIRST_LVD_CYC   (FIRST_LVD_CYC),
   .FIRST_NOLVD_CYC (FIRST_NOLVD_CYC),
   .SUB_LVD_CYC     (SUB_LVD_CYC),
   .SUB_NOLVD_CYC   (SUB_NOLVD_CYC)
) u_chk (
   .clk         (clk),
   .supply_up   (supply_up),
   .supply_down (supply_down),
   .ext_rst_n   (ext_rst_n),
   .lvd_en      (lvd_en),
   .sys_rst     (sys_rst),
   .cpu_run     (cpu_run),
   .first_rel   (first_rel)
);

// File: tb/rst_release_seq_tb.sv
module rst_release_seq_tb;
   localparam int STAB  = 40;
   localparam int FILT  = 5;
   localparam int F_LVD = 30;
   localparam int F_NO  = 18;
   localparam int S_LVD = 24;
   localparam int S_NO  = 12;

   logic clk = 1'b0;
   logic up = 1'b0, down = 1'b1, pin_n = 1'b1, lvd = 1'b1;
   logic sys_rst, cpu_run, first_rel;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   rst_release_seq #(
      .STAB_CYC(STAB), .FILT_CYC(FILT),
      .FIRST_LVD_CYC(F_LVD), .FIRST_NOLVD_CYC(F_NO),
      .SUB_LVD_CYC(S_LVD), .SUB_NOLVD_CYC(S_NO)
   ) u_dut (
      .clk(clk), .supply_up(up), .supply_down(down), .ext_rst_n(pin_n),
      .lvd_en(lvd), .sys_rst(sys_rst), .cpu_run(cpu_run), .first_rel(first_rel)
   );

   // reference model: 0 power-on, 1 stabilizing, 2 pin held, 3 processing, 4 running
   int m_phase = 0;
   int m_left  = 0;
   int m_lows  = 0;
   bit m_first = 1'b1;

   function automatic int proc_len(input bit first, input bit det);
      if (first) return det ? F_LVD : F_NO;
      return det ? S_LVD : S_NO;
   endfunction

   task automatic model_step();
      bit valid;
      valid = !pin_n && (m_lows == FILT - 1);
      if (down) begin
         m_phase = 0; m_first = 1'b1; m_lows = 0;
      end else begin
         case (m_phase)
            0: if (up) begin m_phase = 1; m_left = STAB - 1; end
            1: if (m_left == 0) m_phase = 2; else m_left--;
            2: if (pin_n) begin m_phase = 3; m_left = proc_len(m_first, lvd) - 1; end
            3: if (valid) m_phase = 2;
               else if (m_left == 0) begin m_phase = 4; m_first = 1'b0; end
               else m_left--;
            default: if (valid) m_phase = 2;
         endcase
         if (pin_n) m_lows = 0;
         else if (m_lows < FILT) m_lows++;
      end
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      #2;
      chk(sys_rst == (m_phase != 4), "R3 model sys_rst", int'(sys_rst), int'(m_phase != 4));
      chk(cpu_run == (m_phase == 4), "R11 model cpu_run", int'(cpu_run), int'(m_phase == 4));
      chk(first_rel == m_first, "R10 model first_rel", int'(first_rel), int'(m_first));
   endtask

   task automatic run_to_release(output int n);
      n = 0;
      while (sys_rst && n < 5000) begin cyc(); n++; end
   endtask

   task automatic ext_pulse(input int len);
      pin_n = 1'b0;
      for (int i = 0; i < len; i++) cyc();
      pin_n = 1'b1;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      int burst, dburst;
      #1;
      for (int i = 0; i < 4; i++) cyc();
      chk(sys_rst && !cpu_run && first_rel, "R1 reset state", int'({sys_rst, cpu_run, first_rel}), 3'b101);

      // power-up, detector on, pin high
      down = 1'b0; up = 1'b1; lvd = 1'b1;
      cyc();
      run_to_release(n);
      chk(n == STAB + 1 + F_LVD, "R2 R4 first release lvd", n, STAB + 1 + F_LVD);
      chk(!first_rel, "R10 cleared after first release", int'(first_rel), 0);

      // short pulse rejected
      pin_n = 1'b0;
      for (int i = 0; i < FILT - 1; i++) begin
         cyc();
         chk(cpu_run, "R7 short low keeps running", int'(cpu_run), 1);
      end
      pin_n = 1'b1; cyc();
      chk(cpu_run, "R7 after short low", int'(cpu_run), 1);

      // valid pulse, later release, detector on
      ext_pulse(FILT);
      chk(sys_rst, "R8 valid low asserts reset", int'(sys_rst), 1);
      cyc();
      run_to_release(n);
      chk(n == S_LVD, "R5 later release lvd", n, S_LVD);
      chk(!first_rel, "R10 stays clear", int'(first_rel), 0);

      // detector off, later release; strap flips after processing starts
      lvd = 1'b0;
      ext_pulse(FILT + 3);
      cyc();
      lvd = 1'b1;
      run_to_release(n);
      chk(n == S_NO, "R5 R6 later release no lvd", n, S_NO);

      // power-on with pin held low beyond stabilization, detector off
      down = 1'b1; up = 1'b0; cyc(); cyc();
      chk(first_rel && sys_rst, "R1 fall flag", int'({first_rel, sys_rst}), 3);
      down = 1'b0; up = 1'b1; pin_n = 1'b0; lvd = 1'b0;
      for (int i = 0; i < STAB + 20; i++) cyc();
      chk(sys_rst, "R3 pin low holds reset", int'(sys_rst), 1);
      pin_n = 1'b1; cyc();
      run_to_release(n);
      chk(n == F_NO, "R4 first release no lvd", n, F_NO);

      // abort processing with a valid low
      lvd = 1'b1;
      ext_pulse(FILT); cyc();
      for (int i = 0; i < 6; i++) cyc();
      ext_pulse(FILT);
      chk(sys_rst, "R9 abort holds reset", int'(sys_rst), 1);
      cyc();
      run_to_release(n);
      chk(n == S_LVD, "R9 restart full interval", n, S_LVD);

      // fall flag during processing
      ext_pulse(FILT); cyc(); cyc(); cyc();
      down = 1'b1; cyc(); down = 1'b0;
      chk(first_rel && sys_rst, "R9 R1 fall during processing", int'({first_rel, sys_rst}), 3);
      cyc();
      run_to_release(n);
      chk(n == STAB + 1 + F_LVD, "R9 R2 restart after fall", n, STAB + 1 + F_LVD);

      // constrained random
      void'($urandom(32'd4242));
      burst = 0; dburst = 0;
      for (int i = 0; i < 6000; i++) begin
         if (dburst > 0) dburst--;
         else if ($urandom_range(0, 799) == 0) dburst = $urandom_range(1, 3);
         down = (dburst > 0);
         up   = ($urandom_range(0, 9) != 0);
         if (burst > 0) burst--;
         else if ($urandom_range(0, 59) == 0) burst = $urandom_range(1, 2 * FILT);
         pin_n = (burst == 0);
         if ($urandom_range(0, 199) == 0) lvd = ~lvd;
         cyc();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule